// File: doc/BRIEF.md
# Word-to-Byte FIFO Data Engine

This block sits between a host that deals in 32-bit words and a card-side port that deals in single bytes. A 16-deep word FIFO sits in the middle. The host pushes words into it and pops words out of it. On the card side, bytes cross a valid/ready handshake. A single direction bit picks the way data flows. In receive mode, incoming card bytes are gathered into words, lowest byte lane first, and pushed into the FIFO. In transmit mode, words are popped from the FIFO and handed out one byte at a time, lowest lane first.

A transfer starts when the host programs a byte length and then writes the control register with the enable bit set. A byte counter loaded from that length counts down by one for every byte that crosses the card port. When the counter reaches zero, two sticky end events are raised. The engine then clears its own enable as soon as the FIFO has also drained. Live FIFO flags are presented for the selected direction only, and the other side's flags read as zero. A rounded-up word count of the bytes still remaining is also provided.

Top module: `wbe_engine`

## Requirements
- R1: The FIFO holds 16 words of 32 bits, and `fifo_level` reports 0 to 16. A push while the level is 16 is dropped: the level stays 16 and the stored words are unchanged. A pop while the level is 0 leaves the level at 0 and returns zero on `host_pop_data` in the next cycle.
- R2: In receive mode, the first card byte of a word lands in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24. The word is pushed in the same cycle as its fourth byte.
- R3: In receive mode, if the counter runs out before four bytes are gathered, the partial word is pushed in the cycle of the last byte, and its unfilled upper lanes are zero.
- R4: In transmit mode, each popped word is sent lowest lane first. Sending stops when the counter reaches zero, and any unsent lanes of that word are dropped.
- R5: A control write with `ctrl_enable` high loads `byte_count` from the 16-bit length register (`cfg_len`). A control write with `ctrl_enable` low stops the engine and only sets the direction.
- R6: A byte transfer that takes the counter from 1 to 0 sets both `data_end` and `block_end`. Both stay set until `evt_clear` is pulsed, and a set in the same cycle wins over the clear.
- R7: While enabled, `eng_enable` clears by itself one cycle after `byte_count` is zero and `fifo_level` is zero.
- R8: Flag encoding is {available, empty, full, half}, with bit 3 first. Available means level > 0, empty means level == 0 and full means level == 16. The half bit is level <= 8 on the transmit side and level >= 8 on the receive side.
- R9: When `eng_dir_rx` is 1, `tx_flags` reads 0 and `rx_flags` is live. When it is 0, the reverse holds.
- R10: `word_count` equals (`byte_count` + 3) >> 2.
- R11: At most one byte crosses the card port per cycle, when valid and ready are both high, and each such byte lowers `byte_count` by one. `card_rx_ready` is low unless the engine is enabled in receive mode with a nonzero count and a FIFO that is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_we | input | 1 | Write strobe for the length register |
| cfg_len | input | 16 | Transfer length in bytes |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_enable | input | 1 | Enable bit of a control write |
| ctrl_dir_rx | input | 1 | Direction bit of a control write (1 = card to host) |
| evt_clear | input | 1 | Clears the sticky end events |
| host_push | input | 1 | Push one word into the FIFO |
| host_push_data | input | 32 | Word to push |
| host_pop | input | 1 | Pop one word from the FIFO |
| host_pop_data | output | 32 | Popped word, valid the cycle after `host_pop` |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Offered byte |
| card_rx_ready | output | 1 | Engine accepts a byte |
| card_tx_valid | output | 1 | Engine offers a byte |
| card_tx_data | output | 8 | Offered byte |
| card_tx_ready | input | 1 | Card accepts a byte |
| eng_enable | output | 1 | Engine enable state |
| eng_dir_rx | output | 1 | Current direction |
| byte_count | output | 16 | Bytes remaining |
| word_count | output | 16 | Bytes remaining, rounded up to words |
| fifo_level | output | 5 | Words held in the FIFO |
| tx_flags | output | 4 | Transmit-side flags {avail, empty, full, half-empty} |
| rx_flags | output | 4 | Receive-side flags {avail, empty, full, half-full} |
| data_end | output | 1 | Sticky end-of-data event |
| block_end | output | 1 | Sticky end-of-block event |

## Verification
A wrong lane index in the packer or unpacker shows up as swapped bytes. In receive mode this appears in the first word popped after the transfer. In transmit mode it appears in the very next byte on `card_tx_data`. A counter that slips, or a bad word count, is visible on `byte_count` and `word_count` in the cycle after the faulty step, and it also shifts when `data_end` rises. A FIFO pointer that does not wrap, or a level that overruns, surfaces at the boundary pushes and pops: the flags disagree with the number of accepted pushes, or a popped word does not match the push order.

// File: rtl/wbe_pkg.sv
package wbe_pkg;
  localparam int WBE_WORD_W = 32;
  localparam int WBE_BYTE_W = 8;
  localparam int WBE_DEPTH  = 16;
  localparam int WBE_LEN_W  = 16;

  // Flag bit positions inside tx_flags / rx_flags
  localparam int FLG_HALF  = 0;
  localparam int FLG_FULL  = 1;
  localparam int FLG_EMPTY = 2;
  localparam int FLG_AVAIL = 3;
endpackage

// File: rtl/wbe_fifo.sv
module wbe_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_req,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       rd_req,
  output logic [WORD_W-1:0]          rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              wr_en, rd_en;

  assign wr_en = wr_req && (level != LW'(DEPTH));
  assign rd_en = rd_req && (level != '0);

  // Storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_req) begin
      rd_data <= rd_en ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (level == LW'(DEPTH)) && wr_req && !rd_req |=> level == LW'(DEPTH)); // R1
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (level == '0) && rd_req && !wr_req |=> (rd_data == '0) && (level == '0)); // R1
endmodule

// File: rtl/wbe_packer.sv
module wbe_packer #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IW    = $clog2(LANES);

  logic [WORD_W-1:0] acc;
  logic [IW-1:0]     idx;

  // Lanes above idx stay zero because acc is cleared on every push
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign push_word[k*BYTE_W +: BYTE_W] =
      (idx == IW'(k)) ? byte_in : acc[k*BYTE_W +: BYTE_W];
  end

  assign push = byte_fire && ((idx == IW'(LANES-1)) || last);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc <= '0;
      idx <= '0;
    end else if (push) begin
      acc <= '0;
      idx <= '0;
    end else if (byte_fire) begin
      acc <= push_word;
      idx <= idx + 1'b1;
    end
  end

  AST_PACK_RESTART: assert property (@(posedge clk) disable iff (rst)
    push && !flush |=> (idx == '0) && (acc == '0)); // R3
endmodule

// File: rtl/wbe_unpacker.sv
module wbe_unpacker #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              active,
  input  logic              fifo_empty,
  input  logic              host_pop,
  input  logic [WORD_W-1:0] fifo_rd_data,
  input  logic              byte_ready,
  input  logic              last,
  output logic              fetch,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IW    = $clog2(LANES);

  logic [WORD_W-1:0] word;
  logic [IW-1:0]     idx;
  logic              have, pend, fire;

  assign fetch      = active && !have && !pend && !fifo_empty && !host_pop && !flush;
  assign byte_valid = have && active && !flush;
  assign byte_out   = word[BYTE_W*idx +: BYTE_W];
  assign fire       = byte_valid && byte_ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      have <= 1'b0;
      pend <= 1'b0;
      idx  <= '0;
      word <= '0;
    end else begin
      pend <= fetch;
      if (pend) begin
        word <= fifo_rd_data;
        have <= 1'b1;
        idx  <= '0;
      end else if (fire) begin
        idx <= idx + 1'b1;
        if ((idx == IW'(LANES-1)) || last) have <= 1'b0;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !byte_ready && !flush && !$past(flush) |=> $stable(byte_out)); // R11
endmodule

// File: rtl/wbe_engine.sv
module wbe_engine #(
  parameter int WORD_W = wbe_pkg::WBE_WORD_W,
  parameter int BYTE_W = wbe_pkg::WBE_BYTE_W,
  parameter int DEPTH  = wbe_pkg::WBE_DEPTH,
  parameter int LEN_W  = wbe_pkg::WBE_LEN_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_len_we,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic                       ctrl_we,
  input  logic                       ctrl_enable,
  input  logic                       ctrl_dir_rx,
  input  logic                       evt_clear,
  input  logic                       host_push,
  input  logic [WORD_W-1:0]          host_push_data,
  input  logic                       host_pop,
  output logic [WORD_W-1:0]          host_pop_data,
  input  logic                       card_rx_valid,
  input  logic [BYTE_W-1:0]          card_rx_data,
  output logic                       card_rx_ready,
  output logic                       card_tx_valid,
  output logic [BYTE_W-1:0]          card_tx_data,
  input  logic                       card_tx_ready,
  output logic                       eng_enable,
  output logic                       eng_dir_rx,
  output logic [LEN_W-1:0]           byte_count,
  output logic [LEN_W-1:0]           word_count,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level,
  output logic [3:0]                 tx_flags,
  output logic [3:0]                 rx_flags,
  output logic                       data_end,
  output logic                       block_end
);
  import wbe_pkg::*;

  localparam int LW    = $clog2(DEPTH+1);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int SHIFT = $clog2(LANES);
  localparam int HALF  = DEPTH / 2;

  logic [LEN_W-1:0]  len_r;
  logic              cnt_nz, last, fifo_full, fifo_empty;
  logic              rx_fire, tx_fire, byte_fire;
  logic              pk_push, up_fetch, up_valid, tx_active;
  logic [WORD_W-1:0] pk_word, fifo_wdata;
  logic [BYTE_W-1:0] up_byte;
  logic [LEN_W:0]    wc_sum;
  logic [3:0]        flg_tx_raw, flg_rx_raw;

  assign cnt_nz     = (byte_count != '0);
  assign last       = (byte_count == LEN_W'(1));
  assign fifo_full  = (fifo_level == LW'(DEPTH));
  assign fifo_empty = (fifo_level == '0);

  assign card_rx_ready = eng_enable && eng_dir_rx && cnt_nz && !fifo_full && !ctrl_we;
  assign rx_fire       = card_rx_valid && card_rx_ready;
  assign tx_active     = eng_enable && !eng_dir_rx && cnt_nz;
  assign card_tx_valid = up_valid && !ctrl_we;
  assign card_tx_data  = up_byte;
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign byte_fire     = rx_fire || tx_fire;

  // Length and control registers, byte counter, end events
  always_ff @(posedge clk) begin
    if (rst) begin
      len_r      <= '0;
      eng_enable <= 1'b0;
      eng_dir_rx <= 1'b0;
      byte_count <= '0;
      data_end   <= 1'b0;
      block_end  <= 1'b0;
    end else begin
      if (cfg_len_we) len_r <= cfg_len;
      if (ctrl_we) begin
        eng_enable <= ctrl_enable;
        eng_dir_rx <= ctrl_dir_rx;
        if (ctrl_enable) byte_count <= len_r;
      end else begin
        if (byte_fire) byte_count <= byte_count - 1'b1;
        if (eng_enable && !cnt_nz && fifo_empty) eng_enable <= 1'b0;
      end
      if (evt_clear) begin
        data_end  <= 1'b0;
        block_end <= 1'b0;
      end
      if (byte_fire && last && !ctrl_we) begin
        data_end  <= 1'b1;
        block_end <= 1'b1;
      end
    end
  end

  assign fifo_wdata = pk_push ? pk_word : host_push_data;

  wbe_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (pk_push || host_push),
    .wr_data (fifo_wdata),
    .rd_req  (up_fetch || host_pop),
    .rd_data (host_pop_data),
    .level   (fifo_level)
  );

  wbe_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctrl_we),
    .byte_fire (rx_fire),
    .byte_in   (card_rx_data),
    .last      (last),
    .push      (pk_push),
    .push_word (pk_word)
  );

  wbe_unpacker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
    .clk          (clk),
    .rst          (rst),
    .flush        (ctrl_we),
    .active       (tx_active),
    .fifo_empty   (fifo_empty),
    .host_pop     (host_pop),
    .fifo_rd_data (host_pop_data),
    .byte_ready   (card_tx_ready),
    .last         (last),
    .fetch        (up_fetch),
    .byte_valid   (up_valid),
    .byte_out     (up_byte)
  );

  // Rounded-up word count
  assign wc_sum     = {1'b0, byte_count} + (LEN_W+1)'(LANES-1);
  assign word_count = LEN_W'(wc_sum >> SHIFT);

  // Direction-filtered FIFO flags
  always_comb begin
    flg_tx_raw            = '0;
    flg_rx_raw            = '0;
    flg_tx_raw[FLG_AVAIL] = !fifo_empty;
    flg_tx_raw[FLG_EMPTY] = fifo_empty;
    flg_tx_raw[FLG_FULL]  = fifo_full;
    flg_tx_raw[FLG_HALF]  = (fifo_level <= LW'(HALF));
    flg_rx_raw[FLG_AVAIL] = !fifo_empty;
    flg_rx_raw[FLG_EMPTY] = fifo_empty;
    flg_rx_raw[FLG_FULL]  = fifo_full;
    flg_rx_raw[FLG_HALF]  = (fifo_level >= LW'(HALF));
    tx_flags = eng_dir_rx ? 4'b0000 : flg_tx_raw;
    rx_flags = eng_dir_rx ? flg_rx_raw : 4'b0000;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    byte_fire && !ctrl_we |=> byte_count == $past(byte_count) - 1'b1); // R11
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(rx_fire && tx_fire)); // R11
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(data_end) |-> (byte_count == '0) && block_end); // R6
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_enable) && !$past(ctrl_we) |-> ($past(byte_count) == '0) && ($past(fifo_level) == '0)); // R7
  AST_LOAD_LEN: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && ctrl_enable |=> byte_count == $past(len_r)); // R5
endmodule

// File: tb/sim_wbe_engine.sv
module sim_wbe_engine;
  localparam int CLK_PERIOD = 10;
  // Each vector: {programmed length (32 bits), expected word count (16 bits)}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {32'h0000_0001, 16'd1}, {32'h0000_0003, 16'd1}, {32'h0000_0004, 16'd1},
    {32'h0000_0006, 16'd2}, {32'h0000_0009, 16'd3}, {32'h0001_0005, 16'd2}};

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_len_we = 0, ctrl_we = 0, ctrl_enable = 0, ctrl_dir_rx = 0, evt_clear = 0;
  logic [15:0] cfg_len = '0;
  logic host_push = 0, host_pop = 0;
  logic [31:0] host_push_data = '0, host_pop_data;
  logic card_rx_valid = 0, card_rx_ready, card_tx_valid, card_tx_ready = 0;
  logic [7:0] card_rx_data = '0, card_tx_data;
  logic eng_enable, eng_dir_rx, data_end, block_end;
  logic [15:0] byte_count, word_count;
  logic [4:0] fifo_level;
  logic [3:0] tx_flags, rx_flags;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbe_engine u0 (.*);

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl(input bit en, input bit rx);
    ctrl_we = 1; ctrl_enable = en; ctrl_dir_rx = rx;
    cyc();
    ctrl_we = 0; ctrl_enable = 0;
  endtask

  task automatic pop_word(output logic [31:0] w);
    host_pop = 1;
    cyc();
    host_pop = 0;
    w = host_pop_data;
  endtask

  task automatic clear_events();
    evt_clear = 1;
    cyc();
    evt_clear = 0;
  endtask

  function automatic logic [7:0] rx_byte(input int v, input int k);
    return 8'((v * 16 + k + 1) & 255);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, exp;
    logic [7:0] got [8];
    int nb;
    @(negedge clk);
    cyc();
    rst = 0;
    cyc();
    // Reset state
    chk(fifo_level == 0 && eng_enable == 0, "R1 reset level/enable", {fifo_level, eng_enable}, 0);
    chk(tx_flags == 4'b0101 && rx_flags == 4'b0000, "R8 reset flags", {tx_flags, rx_flags}, 8'h50);
    // R11: no acceptance while idle
    card_rx_valid = 1; card_rx_data = 8'h5A;
    #1;
    chk(card_rx_ready == 0, "R11 ready low while idle", card_rx_ready, 0);
    cyc();
    chk(byte_count == 0 && fifo_level == 0, "R11 idle byte ignored", {byte_count, fifo_level}, 0);
    card_rx_valid = 0;

    // Table of receive transfers
    for (int i = 0; i < NV; i++) begin
      int n;
      n = int'(VEC[i][47:16] & 32'hFFFF);
      cfg_len_we = 1; cfg_len = 16'(VEC[i][47:16]);
      cyc();
      cfg_len_we = 0;
      ctrl(1, 1);
      chk(byte_count == 16'(n), "R5 counter load low 16 bits", byte_count, n);
      chk(word_count == VEC[i][15:0], "R10 word count", word_count, VEC[i][15:0]);
      for (int k = 0; k < n; k++) begin
        card_rx_valid = 1; card_rx_data = rx_byte(i, k);
        #1;
        while (!card_rx_ready) cyc();
        cyc();
      end
      card_rx_valid = 0;
      chk(fifo_level == 5'(VEC[i][15:0]), "R3 words pushed", fifo_level, VEC[i][15:0]);
      chk(data_end && block_end, "R6 end events", {data_end, block_end}, 2'b11);
      chk(eng_enable == 1, "R7 enable held while FIFO holds data", eng_enable, 1);
      for (int wi = 0; wi < int'(VEC[i][15:0]); wi++) begin
        exp = '0;
        for (int l = 0; l < 4; l++)
          if (4*wi + l < n) exp[8*l +: 8] = rx_byte(i, 4*wi + l);
        pop_word(w);
        chk(w == exp, "R2 little-endian packing", w, exp);
      end
      cyc();
      chk(eng_enable == 0, "R7 self clear", eng_enable, 0);
      clear_events();
      chk(!data_end && !block_end, "R6 events cleared", {data_end, block_end}, 0);
    end

    // Transmit: length 6 from two words, last two lanes dropped
    cfg_len_we = 1; cfg_len = 16'd6;
    cyc();
    cfg_len_we = 0;
    ctrl(0, 0);
    host_push = 1; host_push_data = 32'hA4A3A2A1; cyc();
    host_push_data = 32'hB4B3B2B1; cyc();
    host_push = 0;
    ctrl(1, 0);
    card_tx_ready = 1;
    nb = 0;
    for (int c = 0; c < 40; c++) begin
      if (card_tx_valid) begin
        if (nb < 8) got[nb] = card_tx_data;
        nb++;
      end
      cyc();
    end
    card_tx_ready = 0;
    chk(nb == 6, "R4 byte count sent", nb, 6);
    chk({got[0], got[1], got[2], got[3]} == 32'hA1A2A3A4, "R4 low lane first", {got[0], got[1], got[2], got[3]}, 32'hA1A2A3A4);
    chk({got[4], got[5]} == 16'hB1B2, "R4 partial word", {got[4], got[5]}, 16'hB1B2);
    chk(data_end && eng_enable == 0 && fifo_level == 0, "R7 transmit self clear", {data_end, eng_enable, fifo_level}, 7'h40);
    clear_events();

    // Level boundaries, flags, overflow and underflow
    ctrl(0, 0);
    for (int p = 0; p < 17; p++) begin
      host_push = 1; host_push_data = (p == 16) ? 32'hDEAD_BEEF : 32'h100 + 32'(p);
      cyc();
      host_push = 0;
      if (p == 7) chk(tx_flags == 4'b1001, "R8 half-empty at 8", tx_flags, 4'b1001);
      if (p == 8) chk(tx_flags == 4'b1000, "R8 not half-empty at 9", tx_flags, 4'b1000);
      if (p == 15) chk(tx_flags == 4'b1010 && rx_flags == 0, "R9 full on tx side", {tx_flags, rx_flags}, 8'hA0);
    end
    chk(fifo_level == 16, "R1 push to full dropped", fifo_level, 16);
    ctrl(0, 1);
    chk(rx_flags == 4'b1011 && tx_flags == 0, "R9 rx flags only", {rx_flags, tx_flags}, 8'hB0);
    for (int p = 0; p < 16; p++) begin
      pop_word(w);
      chk(w == 32'h100 + 32'(p), "R1 order after wrap", w, 32'h100 + 32'(p));
    end
    pop_word(w);
    chk(w == 0 && fifo_level == 0, "R1 empty pop returns zero", w, 0);
    chk(rx_flags == 4'b0100, "R8 rx empty", rx_flags, 4'b0100);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule